// File: doc/BRIEF.md
# Sprite Attribute DMA Engine

The block copies a fixed run of 160 bytes from a page of system memory into a 256-byte sprite attribute RAM. Software starts a copy by writing the high byte of the source address. The engine then waits a short lead time, reads one source byte per step through its own read port and writes it to the attribute RAM. Destination offsets run upward from zero, and steps follow each other at a fixed interval.

While a copy is in progress, the engine sits between the CPU and the system bus and fences off part of the address map. The sprite attribute window is always fenced. A second window is fenced as well, chosen by the 8 KiB region that the source address falls in and by a model-select input that picks between the older console and the colour console. Reads from a fenced address return 0xFF and never reach the bus. Writes to a fenced address are dropped. All other CPU accesses pass straight through.

The sequencer is an enumerated state machine with these states:
- `S_IDLE`: no copy.
- `S_LEAD`: the initial wait.
- `S_MOVE`: the one-cycle byte transfer.
- `S_PACE`: the wait between bytes.
- `S_DONE`: the one-cycle completion.

Its transitions are:
- *accept*: any state to `S_LEAD` on a valid trigger.
- *lead expiry*: `S_LEAD` to `S_MOVE`.
- *pace expiry*: `S_PACE` to `S_MOVE`.
- *step*: `S_MOVE` to `S_PACE` while bytes remain.
- *finish*: `S_MOVE` to `S_DONE` after the last byte.
- *retire*: `S_DONE` to `S_IDLE`.

Top module: `sprite_dma_engine`

## Requirements
- R1: A trigger whose page byte is above 0xF1 (base address above 0xF100) is ignored, whether the engine is idle or busy. A page byte of exactly 0xF1 starts a copy.
- R2: The first byte is written to the attribute RAM on the 8th rising edge after the edge that samples the trigger. Every later byte is written 4 edges after the previous one.
- R3: A copy writes exactly 160 bytes. Byte k is read from source address base+k (base = page byte followed by 0x00) and written to attribute offset k, for k from 0 to 159.
- R4: While busy, CPU accesses to 0xFE00–0xFE9F are fenced: a read returns 0xFF with bus_rd low, and a write leaves bus_wr low.
- R5: With color_model=0, a source in region 4 (source bits [15:13]=4) fences 0x8000–0x9FFF. A source in any other region fences 0xA000–0xFDFF.
- R6: With color_model=1, region 4 fences 0x8000–0x9FFF, region 6 fences 0xC000–0xFDFF, and every other region fences 0xA000–0xBFFF.
- R7: Every CPU access that is not fenced passes through: bus_rd follows cpu_rd, bus_wr follows cpu_wr, and cpu_rdata equals bus_rdata. Every window has an inclusive low bound and an exclusive high bound.
- R8: In the cycle after the last byte's write edge, busy is low, done is high for exactly one cycle, and no window is fenced any longer.
- R9: A valid trigger accepted while busy restarts the copy from the new base, with R2 timing counted from the new trigger. Only one done pulse follows.
- R10: After reset the engine is idle: busy, done, attr_we and src_rd_en are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| color_model | input | 1 | 0 selects the older console's fences, 1 the colour console's |
| trig_valid | input | 1 | Start request strobe |
| trig_page | input | 8 | High byte of the source base address |
| busy | output | 1 | Copy in progress |
| done | output | 1 | One-cycle completion pulse |
| src_rd_en | output | 1 | Source read strobe |
| src_rd_addr | output | 16 | Source read address |
| src_rd_data | input | 8 | Source read data, same cycle |
| attr_we | output | 1 | Attribute RAM write enable |
| attr_addr | output | 8 | Attribute RAM offset |
| attr_wdata | output | 8 | Attribute RAM write data |
| cpu_addr | input | 16 | CPU access address |
| cpu_rd | input | 1 | CPU read request |
| cpu_wr | input | 1 | CPU write request |
| cpu_rdata | output | 8 | Read data returned to the CPU |
| bus_rd | output | 1 | Read request forwarded to the bus |
| bus_wr | output | 1 | Write request forwarded to the bus |
| bus_rdata | input | 8 | Read data from the bus |

## Verification
Some properties are checked on every cycle:
- The attribute window is fenced while busy.
- Accesses pass through untouched while idle.
- Writes never land on the same edge twice in a row and never go past offset 159.
- done is a single-cycle pulse that directly follows a write.
- An out-of-range trigger never raises busy.

Only the bench's scenarios can show the rest:
- The exact 8/4-edge write schedule against the trigger edge.
- The byte-for-byte source-to-offset mapping.
- Which second window each region and model selects, including both edges of each window.
- Restart on a valid retrigger, and a copy that keeps running through an invalid one.

// File: rtl/sdma_pkg.sv
package sdma_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD,
        S_MOVE,
        S_PACE,
        S_DONE
    } sdma_state_e;

    typedef struct packed {
        logic [15:0] lo;
        logic [15:0] hi;
    } sdma_window_t;

    localparam logic [2:0]  REGION_VIDEO = 3'd4;
    localparam logic [2:0]  REGION_WORK  = 3'd6;
    localparam logic [15:0] ATTR_LO      = 16'hFE00;
    localparam logic [15:0] ATTR_HI      = 16'hFEA0;

    function automatic sdma_window_t fence_window(input logic [2:0] region,
                                                  input logic       color);
        sdma_window_t w;
        if (region == REGION_VIDEO) begin
            w.lo = 16'h8000; w.hi = 16'hA000;
        end else if (!color) begin
            w.lo = 16'hA000; w.hi = 16'hFE00;
        end else if (region == REGION_WORK) begin
            w.lo = 16'hC000; w.hi = 16'hFE00;
        end else begin
            w.lo = 16'hA000; w.hi = 16'hC000;
        end
        return w;
    endfunction

endpackage

// File: rtl/sdma_sequencer.sv
module sdma_sequencer
    import sdma_pkg::*;
#(
    parameter int FIRST_DELAY = 8,
    parameter int BYTE_GAP    = 4,
    parameter int XFER_LEN    = 160
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        busy,
    output logic        move,
    output logic        done
);
    localparam int MAXD = (FIRST_DELAY > BYTE_GAP) ? FIRST_DELAY : BYTE_GAP;
    localparam int CW   = (MAXD > 2) ? $clog2(MAXD) : 1;
    localparam int LW   = $clog2(XFER_LEN + 1);
    localparam logic [CW-1:0] LEAD_LOAD = CW'(FIRST_DELAY - 2);
    localparam logic [CW-1:0] PACE_LOAD = CW'(BYTE_GAP - 2);
    localparam logic [LW-1:0] LEN_LOAD  = LW'(XFER_LEN);

    sdma_state_e   state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic [LW-1:0] left_q, left_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            left_q  <= left_d;
        end
    end

    // transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        left_d  = left_q;
        if (start) begin
            state_d = S_LEAD;           // accept
            cnt_d   = LEAD_LOAD;
            left_d  = LEN_LOAD;
        end else begin
            unique case (state_q)
                S_IDLE: ;
                S_LEAD, S_PACE: begin
                    if (cnt_q == '0) state_d = S_MOVE;   // lead / pace expiry
                    else             cnt_d   = cnt_q - 1'b1;
                end
                S_MOVE: begin
                    left_d = left_q - 1'b1;
                    if (left_q == LW'(1)) begin
                        state_d = S_DONE;                // finish
                    end else begin
                        state_d = S_PACE;                // step
                        cnt_d   = PACE_LOAD;
                    end
                end
                S_DONE: state_d = S_IDLE;                // retire
                default: state_d = S_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        busy = (state_q == S_LEAD) || (state_q == S_MOVE) || (state_q == S_PACE);
        move = (state_q == S_MOVE);
        done = (state_q == S_DONE);
    end

endmodule

// File: rtl/sdma_pointer.sv
module sdma_pointer #(
    parameter int AW  = 16,
    parameter int OAW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [AW-9:0]  page,
    input  logic           move,
    output logic [AW-1:0]  src_addr,
    output logic [OAW-1:0] dst_addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src_addr <= '0;
            dst_addr <= '0;
        end else if (start) begin
            src_addr <= {page, 8'h00};
            dst_addr <= '0;
        end else if (move) begin
            src_addr <= src_addr + 1'b1;
            dst_addr <= dst_addr + 1'b1;
        end
    end
endmodule

// File: rtl/sdma_guard.sv
module sdma_guard
    import sdma_pkg::*;
#(
    parameter logic [7:0] FENCE_DATA = 8'hFF
) (
    input  logic        busy,
    input  logic        color_model,
    input  logic [2:0]  src_region,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    input  logic [7:0]  bus_rdata,
    output logic        bus_rd,
    output logic        bus_wr,
    output logic [7:0]  cpu_rdata
);
    sdma_window_t win;
    logic         in_win, in_attr, fenced;

    always_comb begin
        win     = fence_window(src_region, color_model);
        in_win  = (cpu_addr >= win.lo) && (cpu_addr < win.hi);
        in_attr = (cpu_addr >= ATTR_LO) && (cpu_addr < ATTR_HI);
        fenced  = busy && (in_win || in_attr);
        bus_rd    = cpu_rd && !fenced;
        bus_wr    = cpu_wr && !fenced;
        cpu_rdata = fenced ? FENCE_DATA : bus_rdata;
    end
endmodule

// File: rtl/sprite_dma_engine.sv
module sprite_dma_engine #(
    parameter int         FIRST_DELAY = 8,
    parameter int         BYTE_GAP    = 4,
    parameter int         XFER_LEN    = 160,
    parameter logic [7:0] MAX_PAGE    = 8'hF1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        color_model,
    input  logic        trig_valid,
    input  logic [7:0]  trig_page,
    output logic        busy,
    output logic        done,
    output logic        src_rd_en,
    output logic [15:0] src_rd_addr,
    input  logic [7:0]  src_rd_data,
    output logic        attr_we,
    output logic [7:0]  attr_addr,
    output logic [7:0]  attr_wdata,
    input  logic [15:0] cpu_addr,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    output logic [7:0]  cpu_rdata,
    output logic        bus_rd,
    output logic        bus_wr,
    input  logic [7:0]  bus_rdata
);
    logic start, move;

    assign start = trig_valid && (trig_page <= MAX_PAGE);

    sdma_sequencer #(
        .FIRST_DELAY(FIRST_DELAY),
        .BYTE_GAP   (BYTE_GAP),
        .XFER_LEN   (XFER_LEN)
    ) u_seq (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .busy (busy),
        .move (move),
        .done (done)
    );

    sdma_pointer #(.AW(16), .OAW(8)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .page    (trig_page),
        .move    (move),
        .src_addr(src_rd_addr),
        .dst_addr(attr_addr)
    );

    sdma_guard #(.FENCE_DATA(8'hFF)) u_guard (
        .busy       (busy),
        .color_model(color_model),
        .src_region (src_rd_addr[15:13]),
        .cpu_addr   (cpu_addr),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .bus_rdata  (bus_rdata),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .cpu_rdata  (cpu_rdata)
    );

    assign src_rd_en  = move;
    assign attr_we    = move;
    assign attr_wdata = src_rd_data;

endmodule

// File: rtl/sdma_checker.sv
module sdma_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        trig_valid,
    input logic [7:0]  trig_page,
    input logic        busy,
    input logic        done,
    input logic        attr_we,
    input logic [7:0]  attr_addr,
    input logic [15:0] cpu_addr,
    input logic        cpu_rd,
    input logic        cpu_wr,
    input logic [7:0]  cpu_rdata,
    input logic        bus_rd,
    input logic        bus_wr,
    input logic [7:0]  bus_rdata
);
    assert_reject_page_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trig_valid && trig_page > 8'hF1) |=> !busy);

    assert_write_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
        attr_we |=> !attr_we);

    assert_offset_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        attr_we |-> (attr_addr < 8'd160));

    assert_attr_fence_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cpu_rd && cpu_addr >= 16'hFE00 && cpu_addr < 16'hFEA0)
            |-> (cpu_rdata == 8'hFF && !bus_rd));

    assert_idle_pass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (bus_rd == cpu_rd && bus_wr == cpu_wr && cpu_rdata == bus_rdata));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_after_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(attr_we));
endmodule

bind sprite_dma_engine sdma_checker u_chk (.*);

// File: tb/sprite_dma_engine_test.sv
module sprite_dma_engine_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        color_model = 1'b0;
    logic        trig_valid = 1'b0;
    logic [7:0]  trig_page = 8'h00;
    logic        busy, done, src_rd_en, attr_we, bus_rd, bus_wr;
    logic [15:0] src_rd_addr;
    logic [7:0]  src_rd_data, attr_addr, attr_wdata, cpu_rdata, bus_rdata;
    logic [15:0] cpu_addr = 16'h0000;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;

    int tests = 0;
    int fails = 0;

    function automatic logic [7:0] src_byte(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h5A;
    endfunction

    assign src_rd_data = src_byte(src_rd_addr);
    assign bus_rdata   = cpu_addr[7:0] ^ 8'h33;

    sprite_dma_engine uut (
        .clk(clk), .rst_n(rst_n), .color_model(color_model),
        .trig_valid(trig_valid), .trig_page(trig_page),
        .busy(busy), .done(done),
        .src_rd_en(src_rd_en), .src_rd_addr(src_rd_addr), .src_rd_data(src_rd_data),
        .attr_we(attr_we), .attr_addr(attr_addr), .attr_wdata(attr_wdata),
        .cpu_addr(cpu_addr), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_rdata(cpu_rdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // edge counter and write monitor
    int cyc = 0;
    int trig_edge = 0, nwr = 0, last_wr = 0;
    int err_time = 0, err_addr = 0, err_data = 0;
    int done_cnt = 0, done_cyc = 0;
    logic [15:0] base = 16'h0000;

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (attr_we) begin
                if (cyc != trig_edge + 8 + 4 * nwr) err_time++;
                if (attr_addr != nwr[7:0]) err_addr++;
                if (src_rd_addr != 16'(base + nwr[15:0])) err_addr++;
                if (attr_wdata != src_byte(16'(base + nwr[15:0]))) err_data++;
                last_wr = cyc;
                nwr++;
            end
            if (done) begin
                done_cnt++;
                done_cyc = cyc;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nwr = 0; err_time = 0; err_addr = 0; err_data = 0;
    endtask

    task automatic fire(input logic [7:0] page);
        @(negedge clk); #1;
        trig_valid = 1'b1;
        trig_page  = page;
        if (page <= 8'hF1) begin
            trig_edge = cyc;
            nwr = 0;
            base = {page, 8'h00};
        end
        @(negedge clk); #1;
        trig_valid = 1'b0;
    endtask

    task automatic wait_done(input int d0);
        while (done_cnt == d0) @(negedge clk);
        @(negedge clk); #1;
    endtask

    task automatic check_copy(input int d0, input string tag);
        chk(nwr == 160, {tag, " R3 byte count"}, nwr, 160);
        chk(err_addr == 0 && err_data == 0, {tag, " R3 mapping"}, err_addr + err_data, 0);
        chk(err_time == 0, {tag, " R2 schedule"}, err_time, 0);
        chk(done_cyc == last_wr + 1 && done_cnt == d0 + 1, {tag, " R8 done"}, done_cyc, last_wr + 1);
        chk(!busy, {tag, " R8 busy low"}, busy, 0);
    endtask

    task automatic probe(input logic [15:0] a, input bit fenced, input string req);
        @(negedge clk); #1;
        cpu_addr = a; cpu_rd = 1'b1; cpu_wr = 1'b0;
        #1;
        chk(cpu_rdata == (fenced ? 8'hFF : (a[7:0] ^ 8'h33)) && bus_rd == !fenced,
            req, {a, cpu_rdata}, {a, (fenced ? 8'hFF : (a[7:0] ^ 8'h33))});
        cpu_rd = 1'b0; cpu_wr = 1'b1;
        #1;
        chk(bus_wr == !fenced, req, {a, 7'd0, bus_wr}, {a, 7'd0, !fenced});
        cpu_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk(!busy && !done && !attr_we && !src_rd_en, "R10 reset idle",
            {busy, done, attr_we, src_rd_en}, 0);
    endtask

    task automatic t_plain_copy(input logic [7:0] page, input logic color, input string tag);
        int d0 = done_cnt;
        color_model = color;
        clear_mon();
        fire(page);
        wait_done(d0);
        check_copy(d0, tag);
    endtask

    task automatic t_reject();
        clear_mon();
        fire(8'hF2);
        repeat (30) @(negedge clk);
        chk(!busy && nwr == 0, "R1 page F2 ignored", nwr, 0);
        clear_mon();
        fire(8'hFF);
        repeat (30) @(negedge clk);
        chk(!busy && nwr == 0, "R1 page FF ignored", nwr, 0);
    endtask

    task automatic t_older_video_src();
        int d0 = done_cnt;
        color_model = 1'b0; clear_mon();
        fire(8'h80);
        repeat (3) @(negedge clk);
        probe(16'h8000, 1, "R5 older v lo");
        probe(16'h9FFF, 1, "R5 older v hi");
        probe(16'hA000, 0, "R7 older v above");
        probe(16'h7FFF, 0, "R7 older v below");
        probe(16'hFE00, 1, "R4 attr lo");
        probe(16'hFE9F, 1, "R4 attr hi");
        probe(16'hFEA0, 0, "R7 attr above");
        probe(16'hFDFF, 0, "R7 older v fdff");
        wait_done(d0);
        check_copy(d0, "older video");
        probe(16'h8000, 0, "R8 restored window");
        probe(16'hFE00, 0, "R8 restored attr");
    endtask

    task automatic t_older_other_src();
        int d0 = done_cnt;
        color_model = 1'b0; clear_mon();
        fire(8'hC3);
        repeat (3) @(negedge clk);
        probe(16'hA000, 1, "R5 older other lo");
        probe(16'hFDFF, 1, "R5 older other hi");
        probe(16'h9FFF, 0, "R7 older other below");
        probe(16'hC123, 1, "R5 older other mid");
        probe(16'hFE50, 1, "R4 attr mid");
        wait_done(d0);
        check_copy(d0, "older other");
    endtask

    task automatic t_color_work_src();
        int d0 = done_cnt;
        color_model = 1'b1; clear_mon();
        fire(8'hD0);
        repeat (3) @(negedge clk);
        probe(16'hC000, 1, "R6 colour work lo");
        probe(16'hFDFF, 1, "R6 colour work hi");
        probe(16'hBFFF, 0, "R7 colour work below");
        probe(16'hA000, 0, "R7 colour work a000");
        probe(16'hFE9F, 1, "R4 attr colour");
        wait_done(d0);
        check_copy(d0, "colour work");
    endtask

    task automatic t_color_other_src();
        int d0 = done_cnt;
        color_model = 1'b1; clear_mon();
        fire(8'h01);
        repeat (3) @(negedge clk);
        probe(16'hA000, 1, "R6 colour other lo");
        probe(16'hBFFF, 1, "R6 colour other hi");
        probe(16'hC000, 0, "R7 colour other above");
        probe(16'h9FFF, 0, "R7 colour other below");
        wait_done(d0);
        check_copy(d0, "colour other");
        d0 = done_cnt;
        clear_mon();
        fire(8'h9A);
        repeat (3) @(negedge clk);
        probe(16'h8000, 1, "R6 colour video lo");
        probe(16'hA000, 0, "R6 colour video above");
        wait_done(d0);
        check_copy(d0, "colour video");
    endtask

    task automatic t_retrigger();
        int d0 = done_cnt;
        color_model = 1'b0; clear_mon();
        fire(8'h10);
        repeat (100) @(negedge clk);
        fire(8'h20);
        wait_done(d0);
        check_copy(d0, "R9 valid retrigger");
        d0 = done_cnt;
        clear_mon();
        fire(8'h30);
        repeat (60) @(negedge clk);
        fire(8'hF7);
        chk(busy, "R9 R1 busy after bad retrigger", busy, 1);
        wait_done(d0);
        check_copy(d0, "R9 invalid retrigger");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_plain_copy(8'hC1, 1'b0, "basic");
        t_plain_copy(8'hF1, 1'b0, "R1 page F1 accepted");
        t_reject();
        t_older_video_src();
        t_older_other_src();
        t_color_work_src();
        t_color_other_src();
        t_retrigger();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule